// File: doc/BRIEF.md
# Two-Section Ripple Binary Counter with Modulo Truncation

This block is a 4-bit binary counter made of four toggle stages, each changing state on the falling edge of its own clock. The lowest stage stands alone as a divide-by-two with its own clock input, `clk_a_n`. The upper three stages form a divide-by-eight ripple chain. Each of those stages is clocked by the output of the stage below it. The lowest stage of the chain is clocked either by `clk_b_n` or, when `link_ab` is set, by `qa`. With the link set, the four outputs form one modulo-16 count `{qd, qc, qb, qa}`, with `qd` as the most significant bit.

Two reset inputs are ANDed. While both are high, every stage is cleared at once and held at zero whatever the clocks do. The elaboration parameter `MOD` (2 to 16) shortens the linked count. The bits that are set in `MOD` are decoded from the outputs into an extra clear. The counter therefore touches state `MOD` for zero time and falls back to zero, so it counts 0 to `MOD`-1. `MOD` = 16 leaves the count untruncated.

Top module: `ripple_modn_counter`

## Requirements
- R1: With `link_ab` = 0 and the clear released, every falling edge of `clk_a_n` inverts `qa` and leaves `qb`, `qc` and `qd` unchanged.
- R2: With `link_ab` = 0, every falling edge of `clk_b_n` advances the 3-bit value `{qd, qc, qb}` (`qb` least significant) by one modulo 8 and leaves `qa` unchanged.
- R3: Inside the chain, a falling `qb` clocks `qc` and a falling `qc` clocks `qd`. In an untruncated linked run of 32 edges on `clk_a_n`, `qa`, `qb`, `qc` and `qd` therefore change 32, 16, 8 and 4 times.
- R4: With `link_ab` = 1, `{qd, qc, qb, qa}` counts up by one on each falling edge of `clk_a_n`, wraps from 15 to 0 on the 16th edge, and ignores `clk_b_n`.
- R5: While `rst_a` and `rst_b` are both 1, all four outputs are 0 immediately and stay 0 across edges on either clock.
- R6: The counter counts whenever at least one of `rst_a` and `rst_b` is 0: with only `rst_a` low, with only `rst_b` low, and with both low.
- R7: With `link_ab` = 1 and `MOD` < 16, the visible count runs 0 to `MOD`-1 and returns to 0 on the `MOD`-th falling edge of `clk_a_n`. The clear is decoded as "all bits set in `MOD` are 1 in the outputs".
- R8: With `MOD` = 16, no truncation occurs: the linked count reaches 15.
- R9: If the reset pair goes to both-high in the same instant as a falling `clk_a_n`, the outputs end at 0. After release, the next falling edge gives count 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_n | input | 1 | Falling-edge clock of the standalone divide-by-two stage |
| clk_b_n | input | 1 | Falling-edge clock of the divide-by-eight chain when not linked |
| link_ab | input | 1 | 1: `qa` clocks the chain (full count); 0: `clk_b_n` clocks it. Change only while cleared |
| rst_a | input | 1 | Reset input, ANDed with `rst_b` |
| rst_b | input | 1 | Reset input, ANDed with `rst_a` |
| qa | output | 1 | Bit 0 of the count |
| qb | output | 1 | Bit 1 of the count |
| qc | output | 1 | Bit 2 of the count |
| qd | output | 1 | Bit 3 of the count, most significant |

## Verification
Two events can land in one simulation step: a count edge and a clear. The first case is external. The bench raises both reset inputs in the same step that it drops `clk_a_n`, expects zero, then releases the clear and expects the next edge to give one. The second case is internal. At state `MOD` the decoded clear fires while the ripple is still settling, and the falling outputs of the cleared stages must not clock the stages above them. Seven truncated counters and an untruncated one are run side by side against modular reference counts, so a stray toggle after a self-clear shows up as a wrong count.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;
    localparam int CNT_W     = 4;
    localparam int HI_STAGES = CNT_W - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    // state of one toggle stage
    typedef struct packed {
        logic q;
    } tstage_t;

    // true when every bit set in mask is also set in value
    function automatic logic covers_mask(cnt_t value, cnt_t mask);
        return (value & mask) == mask;
    endfunction
endpackage

// File: rtl/rcnt_tstage.sv
module rcnt_tstage
    import rcnt_pkg::*;
(
    input  logic clk_n,
    input  logic clr,
    output logic q
);
    tstage_t st_d;
    tstage_t st_q;

    always_comb begin
        st_d   = st_q;
        st_d.q = ~st_q.q;
    end

    always_ff @(negedge clk_n or posedge clr) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q = st_q.q;
endmodule

// File: rtl/rcnt_chain.sv
module rcnt_chain #(
    parameter int STAGES = rcnt_pkg::HI_STAGES
) (
    input  logic              clk_n,
    input  logic              clr,
    output logic [STAGES-1:0] q
);
    logic [STAGES-1:0] stage_clk;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_clk[i] = clk_n;
        end else begin : g_ripple
            // a fall caused by the clear itself must not clock the next stage
            assign stage_clk[i] = q[i-1] & ~clr;
        end
        rcnt_tstage u_stage (
            .clk_n (stage_clk[i]),
            .clr   (clr),
            .q     (q[i])
        );
    end
endmodule

// File: rtl/rcnt_clear.sv
module rcnt_clear
    import rcnt_pkg::*;
#(
    parameter int MOD = 16
) (
    input  cnt_t count,
    input  logic rst_a,
    input  logic rst_b,
    input  logic link_ab,
    output logic clr
);
    localparam int   FULL       = 2 ** CNT_W;
    localparam bit   TRUNC_ON   = (MOD < FULL);
    localparam cnt_t TRUNC_MASK = cnt_t'(MOD % FULL);

    typedef struct packed {
        logic ext;
        logic hit;
    } clr_src_t;

    clr_src_t src_d;

    always_comb begin
        src_d.ext = rst_a & rst_b;
        src_d.hit = TRUNC_ON & link_ab & covers_mask(count, TRUNC_MASK);
    end

    assign clr = src_d.ext | src_d.hit;
endmodule

// File: rtl/ripple_modn_counter.sv
module ripple_modn_counter
    import rcnt_pkg::*;
#(
    parameter int MOD = 16
) (
    input  logic clk_a_n,
    input  logic clk_b_n,
    input  logic link_ab,
    input  logic rst_a,
    input  logic rst_b,
    output logic qa,
    output logic qb,
    output logic qc,
    output logic qd
);
    logic                 clr;
    logic                 qa_w;
    logic [HI_STAGES-1:0] hi_q;
    logic                 b_clk;
    cnt_t                 count;

    assign count = {hi_q, qa_w};

    // section B clock: linked to qa (masked during a clear) or external
    assign b_clk = link_ab ? (qa_w & ~clr) : clk_b_n;

    rcnt_tstage u_sec_a (
        .clk_n (clk_a_n),
        .clr   (clr),
        .q     (qa_w)
    );

    rcnt_chain #(.STAGES(HI_STAGES)) u_sec_b (
        .clk_n (b_clk),
        .clr   (clr),
        .q     (hi_q)
    );

    rcnt_clear #(.MOD(MOD)) u_clear (
        .count   (count),
        .rst_a   (rst_a),
        .rst_b   (rst_b),
        .link_ab (link_ab),
        .clr     (clr)
    );

    assign qa = count[0];
    assign qb = count[1];
    assign qc = count[2];
    assign qd = count[3];
endmodule

// File: rtl/ripple_modn_counter_chk.sv
module ripple_modn_counter_chk #(
    parameter int MOD = 16
) (
    input logic clk_a_n,
    input logic clk_b_n,
    input logic link_ab,
    input logic rst_a,
    input logic rst_b,
    input logic qa,
    input logic qb,
    input logic qc,
    input logic qd
);
    logic       frz;
    logic       seen_a;
    logic       seen_b;
    logic [3:0] q4;
    logic [2:0] hi3;

    assign frz = rst_a & rst_b;
    assign q4  = {qd, qc, qb, qa};
    assign hi3 = {qd, qc, qb};

    always_ff @(posedge clk_a_n or posedge frz) begin
        if (frz) seen_a <= 1'b0;
        else     seen_a <= 1'b1;
    end

    always_ff @(posedge clk_b_n or posedge frz) begin
        if (frz) seen_b <= 1'b0;
        else     seen_b <= 1'b1;
    end

    function automatic logic [3:0] next_count(logic [3:0] v);
        logic [4:0] n;
        n = {1'b0, v} + 5'd1;
        return (int'(n) == MOD) ? 4'd0 : n[3:0];
    endfunction

    // R5
    always @(posedge clk_a_n) begin
        if (frz) begin
            freeze_chk: assert (q4 == 4'd0);
        end
    end

    // R1
    a_toggle_chk: assert property (@(posedge clk_a_n) disable iff (frz)
        (seen_a && !link_ab && $past(!link_ab)) |-> (qa != $past(qa)));

    // R2
    b_step_chk: assert property (@(posedge clk_b_n) disable iff (frz)
        (seen_b && !link_ab && $past(!link_ab)) |-> (hi3 == $past(hi3) + 3'd1));

    // R4 R7
    count_step_chk: assert property (@(posedge clk_a_n) disable iff (frz)
        (seen_a && link_ab && $past(link_ab)) |-> (q4 == next_count($past(q4))));
endmodule

bind ripple_modn_counter ripple_modn_counter_chk #(.MOD(MOD)) u_chk (
    .clk_a_n (clk_a_n),
    .clk_b_n (clk_b_n),
    .link_ab (link_ab),
    .rst_a   (rst_a),
    .rst_b   (rst_b),
    .qa      (qa),
    .qb      (qb),
    .qc      (qc),
    .qd      (qd)
);

// File: tb/ripple_modn_counter_tb_top.sv
module ripple_modn_counter_tb_top;
    localparam int NU = 8;
    localparam int MODS [NU] = '{16, 5, 6, 8, 9, 10, 12, 13};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic clk_a_n = 1'b1;
    logic clk_b_n = 1'b1;
    logic link_ab = 1'b0;
    logic rst_a   = 1'b1;
    logic rst_b   = 1'b1;
    logic dqa, dqb, dqc, dqd;
    logic [NU-1:0][3:0] obs;

    ripple_modn_counter dut_i (
        .clk_a_n (clk_a_n), .clk_b_n (clk_b_n), .link_ab (link_ab),
        .rst_a (rst_a), .rst_b (rst_b),
        .qa (dqa), .qb (dqb), .qc (dqc), .qd (dqd)
    );
    assign obs[0] = {dqd, dqc, dqb, dqa};

    for (genvar g = 1; g < NU; g++) begin : g_mod
        logic a, b, c, d;
        ripple_modn_counter #(.MOD(MODS[g])) mod_i (
            .clk_a_n (clk_a_n), .clk_b_n (clk_b_n), .link_ab (1'b1),
            .rst_a (rst_a), .rst_b (rst_b),
            .qa (a), .qb (b), .qc (c), .qd (d)
        );
        assign obs[g] = {d, c, b, a};
    end

    typedef struct {
        int         unit;
        logic [3:0] exp;
        string      req;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    int    ref_cnt [NU];
    int    tg [4];
    int    snap [4];

    always @(dqa) tg[0]++;
    always @(dqb) tg[1]++;
    always @(dqc) tg[2]++;
    always @(dqd) tg[3]++;

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: compares queued expectations away from the driving edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(it.req, {4'd0, obs[it.unit]}, {4'd0, it.exp},
                  $sformatf("unit %0d (MOD %0d)", it.unit, MODS[it.unit]));
        end
    end

    task automatic push_all(input string req);
        for (int u = 0; u < NU; u++) begin
            item_t it;
            it.unit = u;
            it.exp  = 4'(ref_cnt[u]);
            it.req  = req;
            sbq.push_back(it);
        end
    endtask

    task automatic zero_refs();
        for (int u = 0; u < NU; u++) ref_cnt[u] = 0;
    endtask

    task automatic fall_a(input string req);
        @(posedge clk);
        clk_a_n <= 1'b0;
        if (rst_a && rst_b) zero_refs();
        else begin
            for (int u = 1; u < NU; u++) ref_cnt[u] = (ref_cnt[u] + 1) % MODS[u];
            if (link_ab) ref_cnt[0] = (ref_cnt[0] + 1) % 16;
            else         ref_cnt[0] = ref_cnt[0] ^ 1;
        end
        push_all(req);
        @(posedge clk);
        clk_a_n <= 1'b1;
    endtask

    task automatic fall_b(input string req);
        @(posedge clk);
        clk_b_n <= 1'b0;
        if (rst_a && rst_b) zero_refs();
        else if (!link_ab)
            ref_cnt[0] = ((((ref_cnt[0] >> 1) + 1) % 8) << 1) | (ref_cnt[0] & 1);
        push_all(req);
        @(posedge clk);
        clk_b_n <= 1'b1;
    endtask

    task automatic set_rst(input logic a, input logic b, input string req);
        @(posedge clk);
        rst_a <= a;
        rst_b <= b;
        if (a && b) zero_refs();
        push_all(req);
    endtask

    initial begin
        zero_refs();
        repeat (3) @(posedge clk);
        push_all("R5 reset state");
        repeat (3) fall_a("R5 frozen under clk_a_n");
        repeat (3) fall_b("R5 frozen under clk_b_n");

        // only rst_b low: counting, sections independent
        set_rst(1'b1, 1'b0, "R6");
        repeat (3) fall_a("R1");
        repeat (10) fall_b("R2");
        // only rst_a low
        set_rst(1'b0, 1'b1, "R6");
        repeat (2) fall_a("R6 R1");
        repeat (2) fall_b("R6 R2");

        // link the sections under clear, then count with both resets low
        set_rst(1'b1, 1'b1, "R5");
        @(posedge clk);
        link_ab <= 1'b1;
        set_rst(1'b0, 1'b0, "R6");
        repeat (2) @(posedge clk);
        for (int k = 0; k < 4; k++) snap[k] = tg[k];
        repeat (15) fall_a("R4 R7");
        @(negedge clk);
        check("R8", {4'd0, obs[0]}, 8'd15, "untruncated count reaches 15");
        repeat (17) fall_a("R4 R7");
        @(negedge clk);
        check("R3", 8'(tg[0] - snap[0]), 8'd32, "qa change count");
        check("R3", 8'(tg[1] - snap[1]), 8'd16, "qb change count");
        check("R3", 8'(tg[2] - snap[2]), 8'd8,  "qc change count");
        check("R3", 8'(tg[3] - snap[3]), 8'd4,  "qd change count");
        repeat (3) fall_b("R4 clk_b_n ignored when linked");
        repeat (40) fall_a("R7 R8 wrap");

        // clear and clock fall in the same step
        @(posedge clk);
        clk_a_n <= 1'b0;
        rst_a   <= 1'b1;
        rst_b   <= 1'b1;
        zero_refs();
        push_all("R9 clear with clock");
        @(posedge clk);
        clk_a_n <= 1'b1;
        set_rst(1'b0, 1'b0, "R9 release");
        fall_a("R9 first count after clear");
        repeat (2) @(posedge clk);
        @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        #1ms;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        summary();
        $finish;
    end
endmodule